// File: doc/BRIEF.md
# IDE Programmed-I/O Strobe Timer

This block shapes one programmed-I/O task-file access on an IDE channel. It holds a small set of timing registers, kept separately for each of two drives, and runs each host access through three timed phases. First the address phase opens for a programmable setup count. Next the read or write strobe is driven for a programmable pulse count. Last a recovery hold-off lasts for a programmable recovery count before the next access can start its address phase.

Software programs the timing through a byte-wide register port. Two cycle-timing registers sit at offsets 0 and 1, one for reads and one for writes. Each packs a 4-bit pulse count above a 4-bit recovery count. A shared miscellaneous register at offset 6 holds four fields: a drive index, the 2-bit setup count of the indexed drive, a 3-bit delay field and a prefetch flag. The drive index chooses which drive the cycle-timing registers and the setup field refer to. A read-only strap register at offset 5 reports the bus clock selection.

Host accesses arrive on a valid/ready port. The host holds `req_valid`, `req_drive` and `req_write` steady until a clock edge at which `req_ready` is also high. The block is ready when it is idle. It is also ready during recovery while its single waiting slot is empty, so that one further access can queue behind the one in flight. The block never drops a request that has been accepted.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, reading offset 0 or 1 returns 0xFF for either drive index, and offset 6 reads 0x30. This gives setup count 3, pulse count 15 and recovery count 15 for both drives, with index 0, delay 0 and prefetch 0.
- R2: Offset 0 holds the read-cycle timing and offset 1 holds the write-cycle timing. In each, bits 7:4 are the pulse count and bits 3:0 are the recovery count. Writes and reads of both offsets reach the drive selected by the current drive index.
- R3: Offset 6 has the following layout: bit 0 is the drive index, bits 3:1 are the delay field, bits 5:4 are the setup count and bit 6 is the prefetch flag. A write stores the setup count into the drive named by the written bit 0. Bit 7 of a write is ignored and always reads 0.
- R4: Offset 5 reads the `strap_25mhz` input in bit 0, where 0 means 33 MHz and 1 means 25 MHz, with the upper bits 0. Unmapped offsets read 0.
- R5: `req_ready` is high when idle, and also during recovery while no access is waiting. It is low during the setup and strobe phases. An access is taken at a clock edge where `req_valid` and `req_ready` are both high.
- R6: The setup phase starts on the clock after acceptance. During it, `addr_valid` is high and both strobes are low, for (setup count + 1) clocks.
- R7: During the strobe phase, `addr_valid` stays high for (pulse count + 1) clocks. `rd_strobe` is high when `req_write` was 0, using offset 0 of the requested drive. `wr_strobe` is high when `req_write` was 1, using offset 1. The other strobe stays low.
- R8: During the recovery phase, `addr_valid` and both strobes are low for (recovery count + 1) clocks. `ack` is high for exactly one clock, the first clock after the strobe falls.
- R9: An access accepted during recovery starts its setup phase on the clock right after recovery ends, with no idle clock between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` (combinational) |
| strap_25mhz | input | 1 | Bus clock strap, 1 means 25 MHz |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Block can take a request this clock |
| req_drive | input | 1 | Drive addressed by the request |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| addr_valid | output | 1 | Address phase active (setup and strobe) |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| ack | output | 1 | One-clock completion pulse at the end of the strobe |

## Verification
The assertions assume that the request fields stay stable while `req_valid` waits for `req_ready`. They also assume that `cfg_addr` is a known value whenever the read data is checked. The bench changes its inputs only on falling edges. It holds a request until it sees `req_ready` high at a falling edge, and drops it on the next falling edge after acceptance. It keeps one request waiting behind each measured access, so that the recovery length shows up as the gap before the next address phase.

// File: rtl/pio_timer_pkg.sv
package pio_timer_pkg;
  parameter int TCOUNT_W = 4;
  parameter int TSETUP_W = 2;
  parameter int DELAY_W  = 3;
  localparam int PHASE_CNT_W = (TCOUNT_W > TSETUP_W) ? TCOUNT_W : TSETUP_W;

  localparam logic [2:0] OFS_RD_TIMING = 3'd0;
  localparam logic [2:0] OFS_WR_TIMING = 3'd1;
  localparam logic [2:0] OFS_STRAP     = 3'd5;
  localparam logic [2:0] OFS_MISC      = 3'd6;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SETUP   = 2'd1,
    PH_STROBE  = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  typedef struct packed {
    logic [TSETUP_W-1:0] setup;
    logic [TCOUNT_W-1:0] rd_pulse;
    logic [TCOUNT_W-1:0] rd_rec;
    logic [TCOUNT_W-1:0] wr_pulse;
    logic [TCOUNT_W-1:0] wr_rec;
  } drive_timing_t;
endpackage

// File: rtl/pio_drive_bank.sv
module pio_drive_bank
  import pio_timer_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we_rd,
  input  logic                    we_wr,
  input  logic                    we_setup,
  input  logic [2*TCOUNT_W-1:0]   cyc_word,
  input  logic [TSETUP_W-1:0]     setup_in,
  output drive_timing_t           timing
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing <= '1;
    end else begin
      if (we_rd)    {timing.rd_pulse, timing.rd_rec} <= cyc_word;
      if (we_wr)    {timing.wr_pulse, timing.wr_rec} <= cyc_word;
      if (we_setup) timing.setup <= setup_in;
    end
  end
endmodule

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
  import pio_timer_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 3,
  localparam int IDX_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  input  logic                strap_25mhz,
  output logic [DATA_W-1:0]   cfg_rdata,
  output drive_timing_t       timing_all [NUM_DRIVES]
);
  localparam int SETUP_LSB = 1 + DELAY_W;
  localparam int PREF_BIT  = SETUP_LSB + TSETUP_W;

  logic [IDX_W-1:0]   sel_q;
  logic [DELAY_W-1:0] delay_q;
  logic               pref_q;

  logic hit_rd, hit_wr, hit_misc;
  logic [IDX_W-1:0] new_sel;

  assign hit_rd   = cfg_we && (cfg_addr == ADDR_W'(OFS_RD_TIMING));
  assign hit_wr   = cfg_we && (cfg_addr == ADDR_W'(OFS_WR_TIMING));
  assign hit_misc = cfg_we && (cfg_addr == ADDR_W'(OFS_MISC));
  assign new_sel  = cfg_wdata[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      delay_q <= '0;
      pref_q  <= 1'b0;
    end else if (hit_misc) begin
      sel_q   <= new_sel;
      delay_q <= cfg_wdata[DELAY_W:1];
      pref_q  <= cfg_wdata[PREF_BIT];
    end
  end

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drive
    pio_drive_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_rd    (hit_rd && (sel_q == IDX_W'(g))),
      .we_wr    (hit_wr && (sel_q == IDX_W'(g))),
      .we_setup (hit_misc && (new_sel == IDX_W'(g))),
      .cyc_word (cfg_wdata[2*TCOUNT_W-1:0]),
      .setup_in (cfg_wdata[PREF_BIT-1:SETUP_LSB]),
      .timing   (timing_all[g])
    );
  end

  drive_timing_t sel_timing;
  assign sel_timing = timing_all[sel_q];

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      ADDR_W'(OFS_RD_TIMING): cfg_rdata = DATA_W'({sel_timing.rd_pulse, sel_timing.rd_rec});
      ADDR_W'(OFS_WR_TIMING): cfg_rdata = DATA_W'({sel_timing.wr_pulse, sel_timing.wr_rec});
      ADDR_W'(OFS_STRAP):     cfg_rdata = DATA_W'(strap_25mhz);
      ADDR_W'(OFS_MISC):      cfg_rdata = DATA_W'({pref_q, sel_timing.setup, delay_q, sel_q});
      default:                cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_req_slot.sv
module pio_req_slot #(
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             clear,
  input  logic [IDX_W-1:0] in_drive,
  input  logic             in_write,
  output logic             pend_v,
  output logic [IDX_W-1:0] pend_drive,
  output logic             pend_write
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v     <= 1'b0;
      pend_drive <= '0;
      pend_write <= 1'b0;
    end else if (capture) begin
      pend_v     <= 1'b1;
      pend_drive <= in_drive;
      pend_write <= in_write;
    end else if (clear) begin
      pend_v     <= 1'b0;
    end
  end
endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
  import pio_timer_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          launch_write,
  input  drive_timing_t launch_timing,
  output phase_e        phase,
  output logic          rec_last,
  output logic          addr_valid,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic          ack
);
  logic [PHASE_CNT_W-1:0] cnt_q;
  logic [TCOUNT_W-1:0]    pulse_l, rec_l;
  logic                   write_l;
  logic                   cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt_q   <= '0;
      pulse_l <= '0;
      rec_l   <= '0;
      write_l <= 1'b0;
      ack     <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (launch) begin
        phase   <= PH_SETUP;
        cnt_q   <= PHASE_CNT_W'(launch_timing.setup);
        write_l <= launch_write;
        pulse_l <= launch_write ? launch_timing.wr_pulse : launch_timing.rd_pulse;
        rec_l   <= launch_write ? launch_timing.wr_rec   : launch_timing.rd_rec;
      end else begin
        case (phase)
          PH_SETUP: begin
            if (cnt_zero) begin
              phase <= PH_STROBE;
              cnt_q <= PHASE_CNT_W'(pulse_l);
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          PH_STROBE: begin
            if (cnt_zero) begin
              phase <= PH_RECOVER;
              cnt_q <= PHASE_CNT_W'(rec_l);
              ack   <= 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          PH_RECOVER: begin
            if (cnt_zero) phase <= PH_IDLE;
            else          cnt_q <= cnt_q - 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign rec_last   = (phase == PH_RECOVER) && cnt_zero;
  assign addr_valid = (phase == PH_SETUP) || (phase == PH_STROBE);
  assign rd_strobe  = (phase == PH_STROBE) && !write_l;
  assign wr_strobe  = (phase == PH_STROBE) && write_l;
endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_timer_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 3,
  localparam int IDX_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              strap_25mhz,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_drive,
  input  logic              req_write,
  output logic              addr_valid,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              ack
);
  drive_timing_t    timing_all [NUM_DRIVES];
  phase_e           phase;
  logic             rec_last;
  logic             pend_v, pend_write;
  logic [IDX_W-1:0] pend_drive;
  logic             idle, in_rec, accept, launch;
  logic [IDX_W-1:0] l_drive;
  logic             l_write;

  pio_cfg_regs #(
    .NUM_DRIVES (NUM_DRIVES),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .strap_25mhz (strap_25mhz),
    .cfg_rdata   (cfg_rdata),
    .timing_all  (timing_all)
  );

  assign idle      = (phase == PH_IDLE);
  assign in_rec    = (phase == PH_RECOVER);
  assign req_ready = idle || (in_rec && !pend_v);
  assign accept    = req_valid && req_ready;
  assign launch    = (idle && accept) || (rec_last && (pend_v || accept));
  assign l_drive   = pend_v ? pend_drive : req_drive;
  assign l_write   = pend_v ? pend_write : req_write;

  pio_req_slot #(.IDX_W(IDX_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (accept && in_rec && !rec_last),
    .clear      (rec_last && pend_v),
    .in_drive   (req_drive),
    .in_write   (req_write),
    .pend_v     (pend_v),
    .pend_drive (pend_drive),
    .pend_write (pend_write)
  );

  pio_cycle_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .launch        (launch),
    .launch_write  (l_write),
    .launch_timing (timing_all[l_drive]),
    .phase         (phase),
    .rec_last      (rec_last),
    .addr_valid    (addr_valid),
    .rd_strobe     (rd_strobe),
    .wr_strobe     (wr_strobe),
    .ack           (ack)
  );
endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              strap_25mhz,
  input logic              req_ready,
  input logic              addr_valid,
  input logic              rd_strobe,
  input logic              wr_strobe,
  input logic              ack
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe)); // R7

  AST_STROBE_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe || wr_strobe) |-> addr_valid); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> !req_ready); // R5

  AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_valid) |-> !(rd_strobe || wr_strobe)); // R6

  AST_ACK_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ($past(rd_strobe || wr_strobe) && !(rd_strobe || wr_strobe) && !addr_valid)); // R8

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R8

  AST_MISC_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_W'(6)) |-> !cfg_rdata[7]); // R3

  AST_STRAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == ADDR_W'(5)) |-> (cfg_rdata == DATA_W'(strap_25mhz))); // R4
endmodule

bind pio_strobe_timer pio_strobe_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_addr    (cfg_addr),
  .cfg_rdata   (cfg_rdata),
  .strap_25mhz (strap_25mhz),
  .req_ready   (req_ready),
  .addr_valid  (addr_valid),
  .rd_strobe   (rd_strobe),
  .wr_strobe   (wr_strobe),
  .ack         (ack)
);

// File: tb/pio_strobe_timer_test.sv
module pio_strobe_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 6;

  // fields: drive, write, setup[2], rd_pulse[4], rd_rec[4], wr_pulse[4], wr_rec[4]
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 2'd0, 4'd0,  4'd0,  4'd5,  4'd5},
    {1'b0, 1'b1, 2'd1, 4'd7,  4'd7,  4'd2,  4'd3},
    {1'b1, 1'b0, 2'd2, 4'd4,  4'd6,  4'd1,  4'd1},
    {1'b1, 1'b1, 2'd3, 4'd9,  4'd9,  4'd15, 4'd0},
    {1'b0, 1'b0, 2'd3, 4'd15, 4'd15, 4'd0,  4'd0},
    {1'b1, 1'b1, 2'd0, 4'd3,  4'd3,  4'd6,  4'd11}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       strap_25mhz = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_drive = 1'b0;
  logic       req_write = 1'b0;
  logic       addr_valid, rd_strobe, wr_strobe, ack;

  int total = 0;
  int bad   = 0;
  logic drop = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_strobe_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .strap_25mhz(strap_25mhz),
    .req_valid(req_valid), .req_ready(req_ready), .req_drive(req_drive),
    .req_write(req_write), .addr_valid(addr_valid), .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe), .ack(ack)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic step();
    @(negedge clk);
    if (drop) begin req_valid = 1'b0; drop = 1'b0; end
    if (req_valid && req_ready) drop = 1'b1;
  endtask

  // Runs one access with a second one queued behind it; returns phase lengths.
  task automatic measure(input logic d, input logic w, input int es, input int ep,
                         input int er, input string tag);
    int s, p, r, acks, wrong;
    logic ack_first;
    s = 0; p = 0; r = 0; acks = 0; wrong = 0;
    req_drive = d; req_write = w; req_valid = 1'b1; drop = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    while (addr_valid && !rd_strobe && !wr_strobe) begin s++; step(); end
    while (rd_strobe || wr_strobe) begin
      p++;
      if ((w && rd_strobe) || (!w && wr_strobe)) wrong++;
      step();
    end
    ack_first = ack;
    while (!addr_valid) begin r++; if (ack) acks++; step(); end
    check({"R6 setup clocks ", tag}, s, es);
    check({"R7 strobe clocks ", tag}, p, ep);
    check({"R7 other strobe idle ", tag}, wrong, 0);
    check({"R8 ack at strobe fall ", tag}, int'(ack_first), 1);
    check({"R8 single ack ", tag}, acks, 1);
    check({"R8 R9 recovery gap ", tag}, r, er);
    repeat (40) step();
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state, R1
    cfg_read(3'd0, rd); check("R1 read timing drive0", rd, 8'hFF);
    cfg_read(3'd1, rd); check("R1 write timing drive0", rd, 8'hFF);
    cfg_read(3'd6, rd); check("R1 misc reset", rd, 8'h30);
    check("R5 ready at reset", int'(req_ready), 1);
    cfg_write(3'd6, 8'h31);
    cfg_read(3'd0, rd); check("R1 read timing drive1", rd, 8'hFF);
    measure(1'b1, 1'b0, 4, 16, 16, "reset defaults");

    // Vector table: R2 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      logic [19:0] v;
      v = VEC[i];
      cfg_write(3'd6, {2'b00, v[17:16], 3'b000, v[19]});
      cfg_write(3'd0, v[15:8]);
      cfg_write(3'd1, v[7:0]);
      cfg_read(3'd0, rd); check("R2 read timing readback", rd, v[15:8]);
      cfg_read(3'd1, rd); check("R2 write timing readback", rd, v[7:0]);
      if (v[18])
        measure(v[19], 1'b1, int'(v[17:16]) + 1, int'(v[7:4]) + 1, int'(v[3:0]) + 1, "vector");
      else
        measure(v[19], 1'b0, int'(v[17:16]) + 1, int'(v[15:12]) + 1, int'(v[11:8]) + 1, "vector");
    end

    // Per-drive separation, R2: drive0 last got FF, drive1 last got 33
    cfg_write(3'd6, 8'h30);
    cfg_read(3'd0, rd); check("R2 drive0 kept", rd, 8'hFF);
    cfg_write(3'd6, 8'h01);
    cfg_read(3'd0, rd); check("R2 drive1 kept", rd, 8'h33);

    // Misc bit 7 ignored, R3
    cfg_write(3'd6, 8'hFF);
    cfg_read(3'd6, rd); check("R3 misc all ones", rd, 8'h7F);
    cfg_write(3'd6, 8'h80);
    cfg_read(3'd6, rd); check("R3 misc only top bit", rd, 8'h00);
    cfg_write(3'd6, 8'h4B);
    cfg_read(3'd6, rd); check("R3 misc fields", rd, 8'h4B);
    cfg_write(3'd6, 8'h00);
    cfg_read(3'd6, rd); check("R3 setup per drive", rd, 8'h00);

    // Strap and unmapped, R4
    strap_25mhz = 1'b0; cfg_read(3'd5, rd); check("R4 strap 33", rd, 8'h00);
    strap_25mhz = 1'b1; cfg_read(3'd5, rd); check("R4 strap 25", rd, 8'h01);
    cfg_read(3'd7, rd); check("R4 unmapped", rd, 8'h00);

    @(negedge clk);
    check("R5 ready when idle", int'(req_ready), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule